// File: doc/BRIEF.md
# Banked Shared Memory Crossbar Arbiter

This block sits in front of an on-chip SRAM that is cut into several independent banks, and serves every bus master of one compute cluster. Each master has a private request path into every bank. A decode stage turns each master's word address into a bank number and an in-bank word offset. A runtime mode input selects one of two address maps. The interleaved map spreads consecutive words across the banks. The blocked map gives each bank one contiguous address range.

Each bank has its own round-robin arbiter, which picks at most one master per cycle. Masters that target different banks are served in the same cycle and do not affect each other. The grant works as a ready signal: a master keeps its request stable until it sees the grant. A granted write stores its bytes under per-byte strobes in the grant cycle. A granted read returns its word exactly one cycle later, on the response lines of the master that issued it. The banks are plain register arrays.

Top module: `shmem_xbar`

## Requirements
- R1: While reset is active and in the first cycle after it, gnt_o and rvalid_o are all zero. Every bank's round-robin pointer starts at master 0.
- R2: With mode_blocked_i = 0 (interleaved map), a word address A selects bank A mod N_BANK and in-bank offset A / N_BANK.
- R3: With mode_blocked_i = 1 (blocked map), a word address A selects bank A / BANK_DEPTH and in-bank offset A mod BANK_DEPTH. The two maps reach the same storage, so data written under one map can be read back under the other.
- R4: Each bank grants at most one master per cycle. A grant goes only to a master that is requesting that bank. A bank with at least one requester grants one of them in that cycle.
- R5: Masters that request different banks are all granted in the same cycle.
- R6: A bank grants the first requesting master at or after its pointer, searching in cyclic index order. After a grant the pointer moves to the winner's index + 1, wrapping to 0. In a cycle with no grant the pointer keeps its value.
- R7: Read data appears exactly one cycle after the grant. It is on rdata_o of the master that issued the read, with that master's rvalid_o high, and no other master's rvalid_o is raised by it.
- R8: In a write, be_i bit k enables data bits [8k+7:8k]. Bytes whose strobe is 0 keep their old value, so a write with all strobes 0 changes nothing.
- R9: A granted write completes in its grant cycle: a read granted in the next cycle returns the new data. A write never raises rvalid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_blocked_i | input | 1 | Address map: 0 interleaved, 1 blocked |
| req_i | input | N_MST | Request per master, held until granted |
| we_i | input | N_MST | Write enable per master (0 = read) |
| addr_i | input | N_MST*ADDR_W | Word address per master, master m at [m*ADDR_W +: ADDR_W] |
| wdata_i | input | N_MST*DATA_W | Write data per master |
| be_i | input | N_MST*DATA_W/8 | Byte strobes per master |
| gnt_o | output | N_MST | Grant per master; the access is taken this cycle |
| rvalid_o | output | N_MST | Read data valid per master, one cycle after a read grant |
| rdata_o | output | N_MST*DATA_W | Read data per master |

## Verification
The bench builds the block with 4 masters, 4 banks of 8 words and 32-bit data. With these values the whole 32-word memory can be filled and checked. Four masters can pile onto one bank, so the full round-robin rotation and its wrap from the last master back to master 0 can be observed. The blocked map's bank boundaries fall inside a small address range. The bench also switches the mode while requests are pending, so that one held request moves to a different bank when the map changes.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  typedef enum logic {
    MAP_INTERLEAVED = 1'b0,
    MAP_BLOCKED     = 1'b1
  } map_mode_e;
endpackage

// File: rtl/shmem_addr_map.sv
module shmem_addr_map
  import shmem_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int OFF_W  = 7,
  localparam int ADDR_W = BANK_W + OFF_W
) (
  input  map_mode_e         mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFF_W-1:0]  off_o
);
  always_comb begin
    if (mode_i == MAP_BLOCKED) begin
      bank_o = addr_i[ADDR_W-1:OFF_W];
      off_o  = addr_i[OFF_W-1:0];
    end else begin
      bank_o = addr_i[BANK_W-1:0];
      off_o  = addr_i[ADDR_W-1:BANK_W];
    end
  end
endmodule

// File: rtl/shmem_rr_arb.sv
module shmem_rr_arb #(
  parameter int N = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] win_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    win_o = '0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = (int'(ptr_q) + i) % N;
      if (!found && req_i[j]) begin
        found    = 1'b1;
        gnt_o[j] = 1'b1;
        win_o    = IDX_W'(j);
      end
    end
  end

  // pointer moves past the winner only on a granted cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (|gnt_o)   ptr_q <= (int'(win_o) == N - 1) ? '0 : win_o + 1'b1;
  end

  a_r4_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r4_grant_to_requester: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  a_r4_work_conserving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));
  a_r6_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |=> $stable(ptr_q));
endmodule

// File: rtl/shmem_bank.sv
module shmem_bank #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  parameter int MST_W  = 5,
  localparam int OFF_W = $clog2(DEPTH),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [MST_W-1:0]  mst_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [MST_W-1:0]  rmst_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) begin
      for (int k = 0; k < BE_W; k++)
        if (be_i[k]) mem_q[off_i][8*k +: 8] <= wdata_i[8*k +: 8];
    end
    if (en_i && !we_i) rdata_o <= mem_q[off_i];
  end

  // response tag: which master owns the word on rdata_o
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rmst_o   <= '0;
    end else begin
      rvalid_o <= en_i && !we_i;
      if (en_i && !we_i) rmst_o <= mst_i;
    end
  end

  a_r7_resp_from_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(en_i && !we_i));
  a_r9_write_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i) |=> !rvalid_o);
endmodule

// File: rtl/shmem_xbar.sv
module shmem_xbar
  import shmem_pkg::*;
#(
  parameter int N_MST      = 20,
  parameter int N_BANK     = 16,
  parameter int BANK_DEPTH = 128,
  parameter int DATA_W     = 32,
  localparam int BANK_W = $clog2(N_BANK),
  localparam int OFF_W  = $clog2(BANK_DEPTH),
  localparam int ADDR_W = BANK_W + OFF_W,
  localparam int BE_W   = DATA_W / 8,
  localparam int MST_W  = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mode_blocked_i,
  input  logic [N_MST-1:0]         req_i,
  input  logic [N_MST-1:0]         we_i,
  input  logic [N_MST*ADDR_W-1:0]  addr_i,
  input  logic [N_MST*DATA_W-1:0]  wdata_i,
  input  logic [N_MST*BE_W-1:0]    be_i,
  output logic [N_MST-1:0]         gnt_o,
  output logic [N_MST-1:0]         rvalid_o,
  output logic [N_MST*DATA_W-1:0]  rdata_o
);
  map_mode_e mode;
  assign mode = map_mode_e'(mode_blocked_i);

  logic [BANK_W-1:0] bank_of [N_MST];
  logic [OFF_W-1:0]  off_of  [N_MST];

  logic [N_BANK-1:0][N_MST-1:0] bgnt;
  logic              b_rvalid [N_BANK];
  logic [DATA_W-1:0] b_rdata  [N_BANK];
  logic [MST_W-1:0]  b_rmst   [N_BANK];

  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    shmem_addr_map #(.BANK_W(BANK_W), .OFF_W(OFF_W)) u_map (
      .mode_i (mode),
      .addr_i (addr_i[m*ADDR_W +: ADDR_W]),
      .bank_o (bank_of[m]),
      .off_o  (off_of[m])
    );
  end

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic [N_MST-1:0]  breq;
    logic [MST_W-1:0]  win;
    logic [OFF_W-1:0]  sel_off;
    logic              sel_we;
    logic [DATA_W-1:0] sel_wdata;
    logic [BE_W-1:0]   sel_be;

    always_comb begin
      for (int m = 0; m < N_MST; m++)
        breq[m] = req_i[m] && (int'(bank_of[m]) == b);
    end

    shmem_rr_arb #(.N(N_MST)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (breq),
      .gnt_o  (bgnt[b]),
      .win_o  (win)
    );

    always_comb begin
      sel_off   = '0;
      sel_we    = 1'b0;
      sel_wdata = '0;
      sel_be    = '0;
      for (int m = 0; m < N_MST; m++) begin
        if (bgnt[b][m]) begin
          sel_off   = off_of[m];
          sel_we    = we_i[m];
          sel_wdata = wdata_i[m*DATA_W +: DATA_W];
          sel_be    = be_i[m*BE_W +: BE_W];
        end
      end
    end

    shmem_bank #(.DEPTH(BANK_DEPTH), .DATA_W(DATA_W), .MST_W(MST_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (|bgnt[b]),
      .we_i     (sel_we),
      .off_i    (sel_off),
      .wdata_i  (sel_wdata),
      .be_i     (sel_be),
      .mst_i    (win),
      .rvalid_o (b_rvalid[b]),
      .rdata_o  (b_rdata[b]),
      .rmst_o   (b_rmst[b])
    );
  end

  // grant fan-in and tagged response return
  always_comb begin
    gnt_o    = '0;
    rvalid_o = '0;
    rdata_o  = '0;
    for (int m = 0; m < N_MST; m++) begin
      for (int b = 0; b < N_BANK; b++) begin
        if (bgnt[b][m]) gnt_o[m] = 1'b1;
        if (b_rvalid[b] && int'(b_rmst[b]) == m) begin
          rvalid_o[m] = 1'b1;
          rdata_o[m*DATA_W +: DATA_W] = b_rdata[b];
        end
      end
    end
  end

  for (genvar m = 0; m < N_MST; m++) begin : g_chk
    a_r4_gnt_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[m] |-> req_i[m]);
    a_r7_resp_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rvalid_o[m] |-> $past(gnt_o[m] && !we_i[m]));
    a_r7_read_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[m] && !we_i[m]) |=> rvalid_o[m]);
    a_r9_no_write_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[m] && we_i[m]) |=> !rvalid_o[m]);
  end
endmodule

// File: tb/sim_shmem_xbar.sv
module sim_shmem_xbar;
  localparam int NM  = 4;
  localparam int NB  = 4;
  localparam int DEP = 8;
  localparam int DW  = 32;
  localparam int AW  = 5;
  localparam int BEW = DW / 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic mode = 1'b0;
  logic [NM-1:0] req = '0;
  logic [NM-1:0] we = '0;
  logic [AW-1:0] a [NM];
  logic [DW-1:0] wd [NM];
  logic [BEW-1:0] be [NM];

  logic [NM*AW-1:0] addr_f;
  logic [NM*DW-1:0] wdata_f;
  logic [NM*BEW-1:0] be_f;
  logic [NM-1:0] gnt, rvalid;
  logic [NM*DW-1:0] rdata_f;

  always_comb begin
    for (int m = 0; m < NM; m++) begin
      addr_f[m*AW +: AW]   = a[m];
      wdata_f[m*DW +: DW]  = wd[m];
      be_f[m*BEW +: BEW]   = be[m];
    end
  end

  shmem_xbar #(.N_MST(NM), .N_BANK(NB), .BANK_DEPTH(DEP), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_blocked_i(mode),
    .req_i(req), .we_i(we), .addr_i(addr_f), .wdata_i(wdata_f), .be_i(be_f),
    .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata_f)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  int ptr [NB];
  logic [DW-1:0] mm [NB*DEP];
  logic exp_rv [NM];
  logic [DW-1:0] exp_rd [NM];
  logic [NM-1:0] g_exp, g_act, rv_act;
  logic [DW-1:0] rd_act [NM];

  function automatic int bk(input logic md, input int ad);
    return md ? ad / DEP : ad % NB;
  endfunction
  function automatic int ofs(input logic md, input int ad);
    return md ? ad % DEP : ad / NB;
  endfunction
  function automatic logic [DW-1:0] pat(input int ad);
    return 32'h1000_0000 + 32'(ad) * 32'h0101;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [NM-1:0] eg;
    logic nrv [NM];
    logic [DW-1:0] nrd [NM];
    @(negedge clk);
    eg = '0;
    for (int b = 0; b < NB; b++) begin
      bit taken = 1'b0;
      for (int i = 0; i < NM; i++) begin
        int m = (ptr[b] + i) % NM;
        if (!taken && req[m] && bk(mode, int'(a[m])) == b) begin
          taken = 1'b1;
          eg[m] = 1'b1;
        end
      end
    end
    g_act  = gnt;
    rv_act = rvalid;
    for (int m = 0; m < NM; m++) begin
      rd_act[m] = rdata_f[m*DW +: DW];
      chk(gnt[m] == eg[m], tag, $sformatf("R4 R6 gnt m%0d", m), gnt[m], eg[m]);
      chk(rvalid[m] == exp_rv[m], tag, $sformatf("R7 rvalid m%0d", m), rvalid[m], exp_rv[m]);
      if (exp_rv[m])
        chk(rd_act[m] === exp_rd[m], tag, $sformatf("R7 rdata m%0d", m), rd_act[m], exp_rd[m]);
    end
    for (int m = 0; m < NM; m++) begin
      nrv[m] = 1'b0;
      nrd[m] = '0;
      if (eg[m]) begin
        int b = bk(mode, int'(a[m]));
        int p = b * DEP + ofs(mode, int'(a[m]));
        if (we[m]) begin
          for (int k = 0; k < BEW; k++)
            if (be[m][k]) mm[p][8*k +: 8] = wd[m][8*k +: 8];
        end else begin
          nrv[m] = 1'b1;
          nrd[m] = mm[p];
        end
        ptr[b] = (m + 1) % NM;
      end
    end
    for (int m = 0; m < NM; m++) begin
      exp_rv[m] = nrv[m];
      exp_rd[m] = nrd[m];
    end
    g_exp = eg;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    req = '0;
    we  = '0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int ord [4];
    logic [DW-1:0] old6;
    for (int b = 0; b < NB; b++) ptr[b] = 0;
    for (int p = 0; p < NB*DEP; p++) mm[p] = '0;
    for (int m = 0; m < NM; m++) begin
      a[m] = '0; wd[m] = '0; be[m] = '0;
      exp_rv[m] = 1'b0; exp_rd[m] = '0;
    end

    // R1: reset state
    @(negedge clk);
    chk(gnt == '0, "R1", "gnt in reset", gnt, 0);
    chk(rvalid == '0, "R1", "rvalid in reset", rvalid, 0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    step("R1");
    chk(rv_act == '0, "R1", "rvalid after reset", rv_act, 0);

    // R1: pointer starts at 0 -> master 1 beats master 3 on bank 0
    req = 4'b1010; we = 4'b1010;
    a[1] = 5'd0; a[3] = 5'd4;
    wd[1] = 32'hDEAD_0001; wd[3] = 32'hDEAD_0003;
    be[1] = 4'hF; be[3] = 4'hF;
    step("R1");
    chk(g_act == 4'b0010, "R1", "first winner", g_act, 4'b0010);
    req[1] = 1'b0;
    step("R6");
    chk(g_act == 4'b1000, "R6", "held request served", g_act, 4'b1000);
    idle();

    // R2 R5: interleaved fill, every master on its own bank
    mode = 1'b0;
    for (int c = 0; c < DEP; c++) begin
      for (int m = 0; m < NM; m++) begin
        req[m] = 1'b1; we[m] = 1'b1; be[m] = 4'hF;
        a[m] = AW'(c*NB + m);
        wd[m] = pat(c*NB + m);
      end
      step("R2");
      chk(g_act == 4'hF, "R5", "parallel grants", g_act, 4'hF);
    end
    idle();

    // R3: blocked readback of the same storage
    mode = 1'b1;
    for (int c = 0; c < DEP; c++) begin
      for (int m = 0; m < NM; m++) begin
        req[m] = 1'b1; we[m] = 1'b0;
        a[m] = AW'(m*DEP + c);
      end
      step("R3");
      chk(g_act == 4'hF, "R5", "parallel reads", g_act, 4'hF);
      if (c > 0)
        for (int m = 0; m < NM; m++)
          chk(rd_act[m] === pat((c-1)*NB + m), "R3", $sformatf("cross-map m%0d", m),
              rd_act[m], pat((c-1)*NB + m));
    end
    idle();
    step("R7");

    // R4 R6: all masters read bank 2; pointer there is 3 -> order 3,0,1,2
    mode = 1'b0;
    ord = '{3, 0, 1, 2};
    for (int m = 0; m < NM; m++) begin
      req[m] = 1'b1; we[m] = 1'b0; a[m] = 5'd2;
    end
    for (int k = 0; k < 4; k++) begin
      step("R6");
      chk($countones(g_act) == 1, "R4", "single grant", g_act, 1 << ord[k]);
      chk(g_act == 4'(1 << ord[k]), "R6", "rotation order", g_act, 1 << ord[k]);
      for (int m = 0; m < NM; m++) if (g_exp[m]) req[m] = 1'b0;
    end
    idle();
    step("R7");

    // R8 R9: strobed write, read next cycle by another master
    old6 = pat(6);
    req = 4'b0001; we = 4'b0001; a[0] = 5'd6;
    wd[0] = 32'hAABB_CCDD; be[0] = 4'b0101;
    step("R9");
    req = 4'b0010; we = 4'b0000; a[1] = 5'd6;
    step("R9");
    chk(rv_act[0] == 1'b0, "R9", "no write response", rv_act[0], 0);
    idle();
    step("R8");
    chk(rd_act[1] === {old6[31:24], 8'hBB, old6[15:8], 8'hDD}, "R8", "strobed bytes",
        rd_act[1], {old6[31:24], 8'hBB, old6[15:8], 8'hDD});
    req = 4'b0001; we = 4'b0001; wd[0] = 32'h1234_5678; be[0] = 4'b0000;
    step("R8");
    req = 4'b0100; we = 4'b0000; a[2] = 5'd6;
    step("R8");
    idle();
    step("R8");
    chk(rd_act[2] === {old6[31:24], 8'hBB, old6[15:8], 8'hDD}, "R8", "zero strobe",
        rd_act[2], {old6[31:24], 8'hBB, old6[15:8], 8'hDD});

    // mixed random traffic, requests held until granted, map flips mid-flight
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (cyc % 250 == 0) mode = ~mode;
      for (int m = 0; m < NM; m++) begin
        if (!req[m] || g_exp[m]) begin
          req[m] = ($urandom_range(0, 9) < 7);
          we[m]  = $urandom_range(0, 1) == 1;
          a[m]   = AW'($urandom_range(0, NB*DEP - 1));
          wd[m]  = $urandom;
          be[m]  = BEW'($urandom_range(0, 15));
        end
      end
      step("R2 R3 R6 random");
    end
    idle();
    step("R7");
    step("R7");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule